// File: doc/BRIEF.md
# Quadrature Magnetic Scale Position Interpolator

This block turns a pair of sampled sensor voltages from a magnetic linear scale into a fine position. The two channels are in quadrature (90° apart over one pole pitch), so together they trace a circle as the head moves. First the block removes each channel's stored offset and scales it by a stored reciprocal amplitude. It then finds the quarter of the pitch the head is in from which channel is beyond ±1/√2. Inside that quarter a straight-line formula on the other channel gives the position.

A signed count of quarter-pitch crossings adds whole quarters to the in-quarter value. The in-quarter value of the first sample after reset is taken as the origin, so positions are reported relative to where the head was at start-up. One result comes out for every sample strobe, at a fixed latency, with full throughput. Producing offsets and amplitudes is left to software outside the block.

Top module: `mr_pos_est`

## Requirements
- R1: Each channel is normalised as xN = ((sample − offset) · recip) >>> 12, computed in signed arithmetic, where recip is the unsigned value 2^24 / amplitude, so that 4096 stands for 1.0. Channel A uses sampA/offA/recipA and channel B uses sampB/offB/recipB.
- R2: With the threshold T = 2896 (1/√2 in the same scale), region 1 is selected when xNB ≥ T, region 2 when xNA ≥ T, region 3 when xNB ≤ −T and region 4 when xNA ≤ −T. Regions 1→2→3→4 follow increasing position.
- R3: When the sample satisfies none of the four conditions, or more than one, the region is kept from the previous sample. After reset the previous region is region 1.
- R4: With P = 8192 units per pole pitch and S = 1448 (√2·P/8), the in-quarter value is P/8 + ((S·xNA)>>>12) in region 1, P/8 − ((S·xNB)>>>12) in region 2, P/8 − ((S·xNA)>>>12) in region 3 and P/8 + ((S·xNB)>>>12) in region 4.
- R5: The signed quarter count steps by +1 when the region moves to the next one (4 wraps to 1) and by −1 when it moves to the previous one (1 wraps to 4). A jump to the opposite region updates the region but leaves the count unchanged.
- R6: The first sample after reset sets the region without changing the count and stores its in-quarter value as the origin, so its reported position is 0.
- R7: posOut is the 24-bit signed value of the in-quarter value plus count·P/4 minus the origin.
- R8: posValid is high for one cycle per accepted strobe, in the cycle after the third rising edge counted from (and including) the edge that samples sampleValid. Strobes on consecutive cycles each give a result.
- R9: During and right after reset, posValid and posOut are 0, the count is 0, and the next sample becomes a new origin.
- R10: posOut keeps its value in every cycle in which posValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Strobe: sampA and sampB hold a new pair |
| sampA | input | 12 | Channel A sample, unsigned |
| sampB | input | 12 | Channel B sample, unsigned |
| offA | input | 12 | Channel A offset |
| offB | input | 12 | Channel B offset |
| recipA | input | 16 | Channel A reciprocal amplitude, 2^24 / amplitude |
| recipB | input | 16 | Channel B reciprocal amplitude, 2^24 / amplitude |
| posOut | output | 24 | Signed position, 8192 units per pole pitch |
| posValid | output | 1 | posOut holds a new result |

## Verification
The region tracker can step the quarter count for one sample in the same cycle that the output stage adds the previous count into the result of the sample before it. Both also coincide with a new normalisation when strobes arrive back to back. The bench provokes this by sweeping the head angle across several region boundaries forwards and backwards with strobes on consecutive cycles. It judges each result against a scoreboard model that applies the count to the correct sample only. Overlap, empty-region and opposite-jump samples are mixed into the same streams to confirm that the count and region hold or jump as required.

// File: rtl/mr_pos_pkg.sv
package mr_pos_pkg;

  // Strobes handed from the control sequencer to the datapath
  typedef struct packed {
    logic ldNorm;     // capture and normalise a sample pair
    logic ldTrack;    // update region, quarter count and in-quarter value
    logic ldOut;      // form the output position
    logic firstSamp;  // the sample in the tracking stage is the first since reset
  } ctlStrobes_t;

  // Region index: zero-based, following increasing position
  typedef enum logic [1:0] {
    REG_BHI = 2'd0,
    REG_AHI = 2'd1,
    REG_BLO = 2'd2,
    REG_ALO = 2'd3
  } region_e;

endpackage

// File: rtl/mr_pos_ctrl.sv
module mr_pos_ctrl
  import mr_pos_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  output ctlStrobes_t ctl,
  output logic        posValid
);

  logic normDone;
  logic trackDone;
  logic outDone;
  logic firstPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      normDone  <= 1'b0;
      trackDone <= 1'b0;
      outDone   <= 1'b0;
      firstPend <= 1'b1;
    end else begin
      normDone  <= sampleValid;
      trackDone <= normDone;
      outDone   <= trackDone;
      if (normDone) firstPend <= 1'b0;
    end
  end

  always_comb begin
    ctl.ldNorm    = sampleValid;
    ctl.ldTrack   = normDone;
    ctl.ldOut     = trackDone;
    ctl.firstSamp = normDone & firstPend;
  end

  assign posValid = outDone;

endmodule

// File: rtl/mr_pos_norm.sv
module mr_pos_norm #(
  parameter int SAMP_W      = 12,
  parameter int RECIP_W     = 16,
  parameter int RECIP_SHIFT = 12,
  parameter int NORM_W      = 18
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ld,
  input  logic [SAMP_W-1:0]        samp,
  input  logic [SAMP_W-1:0]        off,
  input  logic [RECIP_W-1:0]       recip,
  output logic signed [NORM_W-1:0] xN
);

  localparam int DIFF_W = SAMP_W + 1;
  localparam int PROD_W = DIFF_W + RECIP_W + 1;

  logic signed [DIFF_W-1:0] diff;
  logic signed [PROD_W-1:0] prod;

  always_comb begin
    diff = $signed({1'b0, samp}) - $signed({1'b0, off});
    prod = diff * $signed({1'b0, recip});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) xN <= '0;
    else if (ld) xN <= NORM_W'(prod >>> RECIP_SHIFT);
  end

endmodule

// File: rtl/mr_pos_dp.sv
module mr_pos_dp
  import mr_pos_pkg::*;
#(
  parameter int SAMP_W      = 12,
  parameter int RECIP_W     = 16,
  parameter int RECIP_SHIFT = 12,
  parameter int NORM_W      = 18,
  parameter int NORM_FRAC   = 12,
  parameter int POS_W       = 24,
  parameter int CNT_W       = 16,
  parameter int PITCH       = 8192,
  parameter int SLOPE       = 1448,
  parameter int THRESH      = 2896
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobes_t                   ctl,
  input  logic [1:0][SAMP_W-1:0]        samp,
  input  logic [1:0][SAMP_W-1:0]        off,
  input  logic [1:0][RECIP_W-1:0]       recip,
  output logic signed [POS_W-1:0]       posOut
);

  localparam int EIGHTH  = PITCH / 8;
  localparam int QUARTER = PITCH / 4;
  localparam int NEG_THR = -THRESH;

  logic signed [NORM_W-1:0] xN [2];

  // one normaliser per channel: index 0 is A, index 1 is B
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    mr_pos_norm #(
      .SAMP_W     (SAMP_W),
      .RECIP_W    (RECIP_W),
      .RECIP_SHIFT(RECIP_SHIFT),
      .NORM_W     (NORM_W)
    ) u_norm (
      .clk  (clk),
      .rstN (rstN),
      .ld   (ctl.ldNorm),
      .samp (samp[ch]),
      .off  (off[ch]),
      .recip(recip[ch]),
      .xN   (xN[ch])
    );
  end

  logic [1:0]               regIdx;
  logic [1:0]               nextIdx;
  logic [3:0]               hit;
  logic                     stepUp;
  logic                     stepDn;
  logic signed [CNT_W-1:0]  passCnt;
  logic signed [POS_W-1:0]  localReg;
  logic signed [POS_W-1:0]  pos0;
  logic signed [31:0]       slopeA;
  logic signed [31:0]       slopeB;
  logic signed [31:0]       localComb;
  logic signed [31:0]       sumComb;

  // region conditions
  always_comb begin
    hit[REG_BHI] = (xN[1] >= THRESH);
    hit[REG_AHI] = (xN[0] >= THRESH);
    hit[REG_BLO] = (xN[1] <= NEG_THR);
    hit[REG_ALO] = (xN[0] <= NEG_THR);
    case (hit)
      4'b0001: nextIdx = REG_BHI;
      4'b0010: nextIdx = REG_AHI;
      4'b0100: nextIdx = REG_BLO;
      4'b1000: nextIdx = REG_ALO;
      default: nextIdx = regIdx;   // ambiguous or empty: hold
    endcase
    stepUp = !ctl.firstSamp && (nextIdx == regIdx + 2'd1);
    stepDn = !ctl.firstSamp && (nextIdx == regIdx - 2'd1);
  end

  // piecewise-linear interpolation within the selected quarter
  always_comb begin
    slopeA = (32'(xN[0]) * SLOPE) >>> NORM_FRAC;
    slopeB = (32'(xN[1]) * SLOPE) >>> NORM_FRAC;
    case (nextIdx)
      REG_BHI: localComb = EIGHTH + slopeA;
      REG_AHI: localComb = EIGHTH - slopeB;
      REG_BLO: localComb = EIGHTH - slopeA;
      default: localComb = EIGHTH + slopeB;
    endcase
    sumComb = 32'(localReg) + 32'(passCnt) * QUARTER - 32'(pos0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regIdx   <= REG_BHI;
      passCnt  <= '0;
      localReg <= '0;
      pos0     <= '0;
    end else if (ctl.ldTrack) begin
      regIdx   <= nextIdx;
      localReg <= POS_W'(localComb);
      if (ctl.firstSamp) pos0 <= POS_W'(localComb);
      if (stepUp)      passCnt <= passCnt + CNT_W'(1);
      else if (stepDn) passCnt <= passCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) posOut <= '0;
    else if (ctl.ldOut) posOut <= POS_W'(sumComb);
  end

endmodule

// File: rtl/mr_pos_est.sv
module mr_pos_est
  import mr_pos_pkg::*;
#(
  parameter int SAMP_W      = 12,
  parameter int RECIP_W     = 16,
  parameter int RECIP_SHIFT = 12,
  parameter int NORM_W      = 18,
  parameter int NORM_FRAC   = 12,
  parameter int POS_W       = 24,
  parameter int CNT_W       = 16,
  parameter int PITCH       = 8192,
  parameter int SLOPE       = 1448,
  parameter int THRESH      = 2896
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleValid,
  input  logic [SAMP_W-1:0]       sampA,
  input  logic [SAMP_W-1:0]       sampB,
  input  logic [SAMP_W-1:0]       offA,
  input  logic [SAMP_W-1:0]       offB,
  input  logic [RECIP_W-1:0]      recipA,
  input  logic [RECIP_W-1:0]      recipB,
  output logic signed [POS_W-1:0] posOut,
  output logic                    posValid
);

  ctlStrobes_t ctl;

  mr_pos_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .ctl        (ctl),
    .posValid   (posValid)
  );

  mr_pos_dp #(
    .SAMP_W     (SAMP_W),
    .RECIP_W    (RECIP_W),
    .RECIP_SHIFT(RECIP_SHIFT),
    .NORM_W     (NORM_W),
    .NORM_FRAC  (NORM_FRAC),
    .POS_W      (POS_W),
    .CNT_W      (CNT_W),
    .PITCH      (PITCH),
    .SLOPE      (SLOPE),
    .THRESH     (THRESH)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .samp  ({sampB, sampA}),
    .off   ({offB, offA}),
    .recip ({recipB, recipA}),
    .posOut(posOut)
  );

endmodule

// File: rtl/mr_pos_chk.sv
module mr_pos_chk #(
  parameter int POS_W = 24,
  parameter int CNT_W = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    sampleValid,
  input logic                    posValid,
  input logic signed [POS_W-1:0] posOut,
  input logic                    ldTrack,
  input logic signed [CNT_W-1:0] passCnt
);

  logic [1:0] sinceRst;
  logic       seenOut;
  logic       armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
      seenOut  <= 1'b0;
    end else begin
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
      if (posValid) seenOut <= 1'b1;
    end
  end

  assign armed = (sinceRst == 2'd3);

  // R8
  lat_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(sampleValid, 3)) |-> posValid);

  // R8
  lat_back_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && posValid) |-> $past(sampleValid, 3));

  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && !posValid) |-> $stable(posOut));

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldTrack |=> (passCnt == $past(passCnt) || passCnt == $past(passCnt) + CNT_W'(1)
                 || passCnt == $past(passCnt) - CNT_W'(1)));

  // R5
  cnt_still_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ldTrack |=> $stable(passCnt));

  // R6
  origin_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (posValid && !seenOut) |-> (posOut == '0));

endmodule

bind mr_pos_est mr_pos_chk #(.POS_W(POS_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleValid(sampleValid),
  .posValid   (posValid),
  .posOut     (posOut),
  .ldTrack    (ctl.ldTrack),
  .passCnt    (u_dp.passCnt)
);

// File: tb/tb_mr_pos_est.sv
`timescale 1ns/1ps
module tb_mr_pos_est;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               sampleValid = 1'b0;
  logic [11:0]        sampA = '0, sampB = '0;
  logic [11:0]        offA = 12'd2048, offB = 12'd2048;
  logic [15:0]        recipA = 16'd16777, recipB = 16'd16777;
  logic signed [23:0] posOut;
  logic               posValid;

  mr_pos_est dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampA(sampA), .sampB(sampB), .offA(offA), .offB(offB),
    .recipA(recipA), .recipB(recipB), .posOut(posOut), .posValid(posValid)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  int    expQ[$];
  int    dueQ[$];
  string tagQ[$];

  // reference model state
  int mPrev = 0, mCnt = 0, mPos0 = 0;
  bit mFirst = 1;

  function automatic int normv(int s, int o, int r);
    return ((s - o) * r) >>> 12;
  endfunction

  function automatic int model(int a, int b);
    int xa, xb, nxt, hits, loc, slA, slB;
    xa = normv(a, offA, recipA);
    xb = normv(b, offB, recipB);
    hits = 0; nxt = mPrev;
    if (xb >=  2896) begin hits++; nxt = 0; end
    if (xa >=  2896) begin hits++; nxt = 1; end
    if (xb <= -2896) begin hits++; nxt = 2; end
    if (xa <= -2896) begin hits++; nxt = 3; end
    if (hits != 1) nxt = mPrev;
    slA = (1448 * xa) >>> 12;
    slB = (1448 * xb) >>> 12;
    case (nxt)
      0: loc = 1024 + slA;
      1: loc = 1024 - slB;
      2: loc = 1024 - slA;
      default: loc = 1024 + slB;
    endcase
    if (mFirst) begin
      mPos0 = loc; mFirst = 0;
    end else if (nxt == ((mPrev + 1) % 4)) mCnt++;
    else if (nxt == ((mPrev + 3) % 4)) mCnt--;
    mPrev = nxt;
    return loc + mCnt * 2048 - mPos0;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // driver: one strobe per call, consecutive calls give back-to-back strobes
  task automatic send(int a, int b, string tag);
    @(negedge clk);
    sampleValid = 1'b1;
    sampA = 12'(a);
    sampB = 12'(b);
    expQ.push_back(model(a, b));
    dueQ.push_back(cyc + 3);
    tagQ.push_back(tag);
  endtask

  task automatic sendAngle(real deg, string tag);
    real th;
    int a, b;
    th = deg * 3.14159265358979 / 180.0;
    a = 2048 + $rtoi($floor(1000.0 * $sin(th) + 0.5));
    b = 2048 + $rtoi($floor(1000.0 * $cos(th) + 0.5));
    send(a, b, tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleValid = 1'b0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    sampleValid = 1'b0;
    rstN = 1'b0;
    mPrev = 0; mCnt = 0; mPos0 = 0; mFirst = 1;
    repeat (3) @(negedge clk);
    check(posValid == 1'b0, "R9 posValid in reset", int'(posValid), 0);
    check(posOut == '0, "R9 posOut in reset", int'(posOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(posValid == 1'b0 && posOut == '0, "R9 after reset", int'(posOut), 0);
  endtask

  // monitor / scoreboard
  int lastOut = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (!rstN) begin
        lastOut = 0;
      end else if (posValid) begin
        if (expQ.size() == 0) begin
          check(0, "R8 unexpected posValid", 1, 0);
        end else begin
          int e, d;
          string t;
          e = expQ.pop_front();
          d = dueQ.pop_front();
          t = tagQ.pop_front();
          check(int'(posOut) == e, t, int'(posOut), e);
          check(d == cyc, "R8 result cycle", cyc, d);
        end
        lastOut = int'(posOut);
      end else begin
        if (dueQ.size() != 0 && dueQ[0] <= cyc) begin
          check(0, "R8 missing result", 0, expQ[0]);
          void'(expQ.pop_front());
          void'(dueQ.pop_front());
          void'(tagQ.pop_front());
        end
        check(int'(posOut) == lastOut, "R10 hold", int'(posOut), lastOut);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    // R6: first sample is origin
    sendAngle(30.0, "R6 origin");
    idle(4);
    // R2 R4 R5 R7: forward sweep, back-to-back strobes
    for (int k = 1; k <= 48; k++) sendAngle(30.0 + 15.0 * k, "R2/R4/R5/R7 forward");
    idle(2);
    // backward sweep with gaps, count goes negative
    for (int k = 47; k >= -20; k--) begin
      sendAngle(30.0 + 15.0 * k, "R5/R7 backward");
      idle(k % 3);
    end
    idle(4);
    // R3: both A and B beyond the threshold, then neither
    sendAngle(10.0, "R4 region 1 entry");
    send(2848, 2848, "R3 overlap holds region");
    send(2048, 2048, "R3 empty holds region");
    sendAngle(80.0, "R3 after hold");
    idle(3);
    // R5: opposite jump, no count step
    sendAngle(90.0, "R5 region 2");
    sendAngle(270.0, "R5 opposite jump");
    sendAngle(280.0, "R5 after jump");
    sendAngle(0.0, "R5 wrap 4 to 1");
    sendAngle(-80.0, "R5 wrap 1 to 4");
    idle(4);
    // R1: new calibration on channel A
    offA = 12'd2000;
    recipA = 16'd20972;
    send(2000 + 790, 2048, "R1 recal A high");
    send(2000 - 100, 2048 + 990, "R1 recal B high");
    send(2000 - 790, 2048, "R1 recal A low");
    idle(4);
    offA = 12'd2048;
    recipA = 16'd16777;
    // R9: mid-run reset and new origin
    sendAngle(100.0, "R7 pre-reset");
    idle(4);
    doReset();
    sendAngle(200.0, "R9 new origin");
    sendAngle(230.0, "R7 after new origin");
    idle(6);
    check(expQ.size() == 0, "R8 all results delivered", expQ.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule